// File: doc/BRIEF.md
# Zero-Crossing Timing Quality Detector

This block grades every zero crossing of a received baseband signal. It compares the moment the crossing arrives with the moment the recovered bit clock predicts. The recovered clock is given to it as a phase count that sweeps once per bit period. The crossing is marked by a one-cycle strobe. A crossing that lands close enough to the predicted phase is graded good; any other crossing is graded bad.

The block drives a single logic-level quality flag from these grades. The flag rises only after a run of consecutive good crossings and falls on any single bad crossing. The fraction of time the flag is high can be averaged downstream to estimate the signal-to-noise ratio. While the receive path is in powersave, the flag is held low.

The block depends only on the strobe and the phase count. It therefore keeps grading while the clock loop freewheels.

Top module: `zcq_quality_detect`

## Requirements
- R1: After reset the quality flag `qualityOk` is 0 and the count of consecutive good crossings is zero, so `RUN_LEN` good crossings are needed before the flag can rise.
- R2: `phaseCnt` counts 0 to 2^`PHASE_W`-1 over one bit period. A crossing is good when the absolute phase error against `EXPECT_PHASE` is at most `2^PHASE_W / WINDOW_DIV` steps, and bad otherwise. With the defaults (64 steps, expected phase 0, divisor 8) phases 0 to 8 and 56 to 63 are good, and 9 to 55 are bad.
- R3: The phase error is taken modulo one bit period. A crossing just before the bit boundary (phase 62 with expected phase 0) counts as a small negative error. A crossing half a bit away (phase 32) is bad.
- R4: A bad crossing sampled at clock edge N drives `qualityOk` to 0 after edge N+1 and restarts the good-run count.
- R5: `qualityOk` rises after edge N+1, where edge N samples the `RUN_LEN`-th consecutive good crossing (default 2). It never rises on fewer.
- R6: With no crossing strobe and no powersave, `qualityOk` keeps its value over any number of cycles.
- R7: While `rxSleep` is 1, `qualityOk` is 0 from the next clock edge on. Crossings are ignored and the good-run count is cleared, so after `rxSleep` returns to 0 a full run of `RUN_LEN` good crossings is needed again.
- R8: Further good crossings while `qualityOk` is 1 keep it at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| xingStrobe | input | 1 | One-cycle pulse marking a detected zero crossing |
| phaseCnt | input | PHASE_W | Recovered-clock phase within the current bit, sampled with the strobe |
| rxSleep | input | 1 | Receive powersave; forces the flag low and discards crossings |
| qualityOk | output | 1 | Timing quality flag: 1 after a run of good crossings |

## Verification
The assertions take for granted that `xingStrobe` is a single-cycle pulse. They also assume that powersave and crossings are not applied in ways that overlap the two-cycle grading pipeline in contradictory ways. For example, no crossing is graded in the same cycle that powersave releases. The directed stimulus changes inputs only on the falling clock edge and spaces crossings two cycles apart. It toggles `rxSleep` only while no crossing is in flight, so every grade reaches the flag logic with a known powersave state.

// File: rtl/zcq_pkg.sv
package zcq_pkg;
  // Grade strobes passed from the timing datapath to the flag control.
  typedef struct packed {
    logic good;
    logic bad;
  } gradeT;
endpackage

// File: rtl/zcq_grader.sv
module zcq_grader
  import zcq_pkg::*;
#(
  parameter int PHASE_W      = 6,
  parameter int EXPECT_PHASE = 0,
  parameter int WINDOW_DIV   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xingStrobe,
  input  logic [PHASE_W-1:0] phaseCnt,
  output gradeT              gradeOut
);
  localparam int STEPS  = 1 << PHASE_W;
  localparam int WINDOW = STEPS / WINDOW_DIV;
  localparam logic [PHASE_W-1:0] EXP_P = PHASE_W'(EXPECT_PHASE);

  logic [PHASE_W-1:0] rawErr;
  logic [PHASE_W:0]   errExt;
  logic [PHASE_W:0]   errMag;
  logic               inWindow;

  // Modulo-period subtraction: a W-bit two's-complement result wraps at the bit boundary.
  always_comb begin
    rawErr   = phaseCnt - EXP_P;
    errExt   = {rawErr[PHASE_W-1], rawErr};
    errMag   = errExt[PHASE_W] ? (~errExt + 1'b1) : errExt;
    inWindow = (errMag <= (PHASE_W+1)'(WINDOW));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gradeOut <= '0;
    end else begin
      gradeOut.good <= xingStrobe & inWindow;
      gradeOut.bad  <= xingStrobe & ~inWindow;
    end
  end

  // R2: every crossing yields exactly one grade on the following edge
  assert_one_grade_R2: assert property (@(posedge clk) disable iff (!rstN)
    xingStrobe |=> (gradeOut.good ^ gradeOut.bad));

  // R6: no grade appears without a crossing
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rstN)
    !xingStrobe |=> !(gradeOut.good || gradeOut.bad));
endmodule

// File: rtl/zcq_tracker.sv
module zcq_tracker
  import zcq_pkg::*;
#(
  parameter int RUN_LEN = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  rxSleep,
  input  gradeT gradeIn,
  output logic  qualityOk
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

  logic [RUN_W-1:0] goodRun;
  logic [RUN_W-1:0] nextRun;

  always_comb begin
    nextRun = (goodRun == RUN_MAX) ? goodRun : goodRun + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goodRun   <= '0;
      qualityOk <= 1'b0;
    end else if (rxSleep || gradeIn.bad) begin
      goodRun   <= '0;
      qualityOk <= 1'b0;
    end else if (gradeIn.good) begin
      goodRun   <= nextRun;
      qualityOk <= (nextRun == RUN_MAX);
    end
  end

  // R7: powersave pulls the flag low on the next edge
  assert_sleep_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxSleep |=> !qualityOk);

  // R4: any bad grade pulls the flag low
  assert_bad_drops_R4: assert property (@(posedge clk) disable iff (!rstN)
    gradeIn.bad |=> !qualityOk);

  // R5: a rise is always caused by a good grade
  assert_rise_on_good_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qualityOk) |-> $past(gradeIn.good));

  // R6: without grades or powersave the flag holds
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!rxSleep && !gradeIn.good && !gradeIn.bad) |=> $stable(qualityOk));
endmodule

// File: rtl/zcq_quality_detect.sv
module zcq_quality_detect
  import zcq_pkg::*;
#(
  parameter int PHASE_W      = 6,
  parameter int EXPECT_PHASE = 0,
  parameter int WINDOW_DIV   = 8,
  parameter int RUN_LEN      = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xingStrobe,
  input  logic [PHASE_W-1:0] phaseCnt,
  input  logic               rxSleep,
  output logic               qualityOk
);
  gradeT grade;

  zcq_grader #(
    .PHASE_W     (PHASE_W),
    .EXPECT_PHASE(EXPECT_PHASE),
    .WINDOW_DIV  (WINDOW_DIV)
  ) uGrader (
    .clk       (clk),
    .rstN      (rstN),
    .xingStrobe(xingStrobe),
    .phaseCnt  (phaseCnt),
    .gradeOut  (grade)
  );

  zcq_tracker #(
    .RUN_LEN(RUN_LEN)
  ) uTracker (
    .clk      (clk),
    .rstN     (rstN),
    .rxSleep  (rxSleep),
    .gradeIn  (grade),
    .qualityOk(qualityOk)
  );
endmodule

// File: tb/sim_zcq_quality_detect.sv
module sim_zcq_quality_detect;
  localparam int CLK_PERIOD = 10;
  localparam int PW         = 6;
  localparam int STEPS      = 64;
  localparam int WIN        = 8;
  localparam int RUN        = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          xingStrobe = 1'b0;
  logic [PW-1:0] phaseCnt = '0;
  logic          rxSleep = 1'b0;
  logic          qualityOk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zcq_quality_detect u0 (
    .clk(clk), .rstN(rstN), .xingStrobe(xingStrobe),
    .phaseCnt(phaseCnt), .rxSleep(rxSleep), .qualityOk(qualityOk)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive a crossing on a falling edge; return after the flag has settled.
  task automatic sendXing(input int ph);
    xingStrobe = 1'b1;
    phaseCnt   = PW'(ph);
    @(negedge clk);
    xingStrobe = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit modelGood(input int ph);
    int d;
    d = ph % STEPS;
    if (d > STEPS/2) d = STEPS - d;
    return d <= WIN;
  endfunction

  task automatic test_reset();
    check("R1 reset flag", qualityOk, 0);
    sendXing(0);
    check("R1 single good after reset", qualityOk, 0);
    sendXing(1);
    check("R1 second good after reset", qualityOk, 1);
  endtask

  task automatic test_window_edges();
    sendXing(32);
    sendXing(8); sendXing(8);
    check("R2 phase 8 good", qualityOk, 1);
    sendXing(9);
    check("R2 phase 9 bad", qualityOk, 0);
    sendXing(56); sendXing(56);
    check("R2 phase 56 good", qualityOk, 1);
    sendXing(55);
    check("R2 phase 55 bad", qualityOk, 0);
  endtask

  task automatic test_wrap();
    sendXing(62); sendXing(63);
    check("R3 wrap near boundary good", qualityOk, 1);
    sendXing(32);
    check("R3 half bit bad", qualityOk, 0);
  endtask

  task automatic test_bad_drop();
    sendXing(0); sendXing(0);
    // R4: drive bad crossing, sample after one edge (not yet) and after two
    xingStrobe = 1'b1; phaseCnt = PW'(20);
    @(negedge clk);
    xingStrobe = 1'b0;
    check("R4 flag before grade lands", qualityOk, 1);
    @(negedge clk);
    check("R4 flag after bad", qualityOk, 0);
  endtask

  task automatic test_run_length();
    sendXing(3);
    check("R5 one good not enough", qualityOk, 0);
    sendXing(40);
    sendXing(4);
    check("R5 run broken by bad", qualityOk, 0);
    sendXing(60);
    check("R5 two goods raise flag", qualityOk, 1);
    sendXing(2); sendXing(5);
    check("R8 stays high on more goods", qualityOk, 1);
  endtask

  task automatic test_idle_hold();
    repeat (20) @(negedge clk);
    check("R6 high held while idle", qualityOk, 1);
    sendXing(16);
    repeat (20) @(negedge clk);
    check("R6 low held while idle", qualityOk, 0);
  endtask

  task automatic test_sleep();
    sendXing(0); sendXing(0);
    rxSleep = 1'b1;
    @(negedge clk);
    check("R7 sleep forces low", qualityOk, 0);
    sendXing(0); sendXing(0); sendXing(1);
    check("R7 crossings ignored in sleep", qualityOk, 0);
    rxSleep = 1'b0;
    @(negedge clk);
    sendXing(0);
    check("R7 run restarted after sleep", qualityOk, 0);
    sendXing(0);
    check("R7 recovers after full run", qualityOk, 1);
  endtask

  task automatic test_jitter();
    int run;
    bit flag;
    int expHigh;
    int actHigh;
    int mism;
    sendXing(32);
    run = 0; flag = 0; expHigh = 0; actHigh = 0; mism = 0;
    for (int i = 0; i < 60; i++) begin
      int ph;
      ph = (i % 5 == 3) ? ((i * 13) % STEPS) : ((STEPS + ((i * 7) % 21) - 10) % STEPS);
      sendXing(ph);
      if (modelGood(ph)) begin
        if (run < RUN) run++;
        flag = (run == RUN);
      end else begin
        run = 0; flag = 0;
      end
      if (flag) expHigh++;
      if (qualityOk) actHigh++;
      if (qualityOk != flag) mism++;
    end
    check("R2 R5 jitter high count", actHigh, expHigh);
    check("R4 jitter per-crossing mismatches", mism, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_window_edges();
    test_wrap();
    test_bad_drop();
    test_run_length();
    test_idle_hold();
    test_sleep();
    test_jitter();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule